// File: doc/BRIEF.md
# Memory Wait-State Generator

This block tells the CPU bus how long to stall each memory access. Each access brings a region index, taken from the address bits above the in-region offset. It also brings a width flag (16 or 32 bits), a sequential flag and a one-cycle start strobe. The block looks up the per-region 16-bit wait figures and derives the cost of the requested access from them. It then holds a stall output high for that many cycles and finishes with a one-cycle done pulse. An access that costs nothing is completed in the cycle it starts.

Most regions have fixed figures. Three cartridge windows and a save-RAM window take their timing from a 16-bit control word. Each cartridge window spans two adjacent regions: a base region and its mirror. A write to the control word is seen by the next access that starts. An access that is already stalling keeps the count it latched when it started. Control bit 14 is brought out as a registered prefetch-enable level for a neighbouring block.

Top module: `mem_wait_gen`

## Requirements
- R1: For regions 0-7 and 15, the 16-bit wait is fixed. Region 2 costs 2 cycles, both sequential and non-sequential. Every other region in this set costs 0.
- R2: A region index greater than 15 costs 0 cycles at either width and either sequential setting.
- R3: A 32-bit non-sequential access costs N16 + S16 + 1. A 32-bit sequential access costs 2*S16 + 1. N16 and S16 are the region's 16-bit non-sequential and sequential waits.
- R4: The 2-bit non-sequential code of a cartridge window maps 0→4, 1→3, 2→2, 3→8 cycles. The fields sit at control bits 3:2 (window 0, regions 8/9), 6:5 (window 1, regions 10/11) and 9:8 (window 2, regions 12/13).
- R5: A window's sequential bit sits at control bit 4, 7 or 10 for windows 0, 1 and 2. When set, S16 is 1. When clear, S16 is 2, 4 or 8 for windows 0, 1 and 2.
- R6: Region 14 (save RAM) uses the code in control bits 1:0, mapped as in R4, for both N16 and S16. Its 32-bit cost is therefore twice that value plus one.
- R7: Both regions of a cartridge window always report the same waits.
- R8: After reset, stall and done are low, the prefetch level is low and the control word is zero. With a zero word, cartridge regions cost N16=4 and S16=2/4/8, and region 14 costs 4.
- R9: An access with cost N>0 started in cycle 0 holds stall high in cycles 1..N. Done is high for exactly cycle N+1, with stall low in that cycle.
- R10: An access with cost 0 raises done in the same cycle as its start strobe, and stall stays low.
- R11: A control write takes effect for accesses that start after the write cycle. A start in the write cycle itself, or an access already stalling, uses the previous settings.
- R12: A start strobe that arrives while stall is high is ignored. It adds no cycles and produces no done pulse.
- R13: The prefetch level equals control bit 14 from the cycle after a write. Control bits 11-13 and 15 change no wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word value |
| acc_start | input | 1 | One-cycle access start strobe |
| acc_rgn | input | RGN_W (8) | Region index (address bits above the region offset) |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| acc_seq | input | 1 | 1 = sequential access |
| stall_o | output | 1 | Bus wait, high while the access is stalling |
| done_o | output | 1 | One-cycle access completion pulse |
| pf_en_o | output | 1 | Prefetch enable level (control bit 14) |

## Verification
Every fault inside this block shows up at the ports within one access, as a wrong number of stall cycles before the done pulse. A swapped field position or a wrong code map changes only the regions that depend on that field. The bench therefore sweeps every code and every sequential bit across both regions of each window. A counter that reloads on a stray start, or config that is not latched, lengthens the current stall. Stale or early config shows up in the very next access, so the mid-stall and same-cycle write cases are timed against it.

// File: rtl/ws_pkg.sv
package ws_pkg;

  parameter int WS_CNT_W   = 5;
  parameter int NUM_RGN    = 16;
  parameter int NUM_WIN    = 3;
  parameter int WIN_BASE   = 8;
  parameter int SAVE_RGN   = 14;
  parameter int NS_LSB     = 2;
  parameter int SQ_BIT     = 4;
  parameter int FIELD_STEP = 3;
  parameter int PF_BIT     = 14;

  typedef struct packed {
    logic [WS_CNT_W-1:0] ns;
    logic [WS_CNT_W-1:0] sq;
  } ws_pair_t;

  function automatic logic [WS_CNT_W-1:0] ns_map(input logic [1:0] code);
    case (code)
      2'd0:    return WS_CNT_W'(4);
      2'd1:    return WS_CNT_W'(3);
      2'd2:    return WS_CNT_W'(2);
      default: return WS_CNT_W'(8);
    endcase
  endfunction

  function automatic logic [WS_CNT_W-1:0] sq_map(input int win, input logic fast);
    if (fast) return WS_CNT_W'(1);
    return WS_CNT_W'(2 << win);
  endfunction

  function automatic ws_pair_t fixed_pair(input int rgn);
    ws_pair_t p;
    p.ns = (rgn == 2) ? WS_CNT_W'(2) : '0;
    p.sq = p.ns;
    return p;
  endfunction

endpackage

// File: rtl/ws_ctl_reg.sv
module ws_ctl_reg #(
  parameter int CTL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [10:0]      fields,
  output logic             pf_en
);
  logic [10:0] fld_q;
  logic        pf_q;
  logic        unused_rsvd;

  assign unused_rsvd = ^{wdata[CTL_W-1], wdata[13:11]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= '0;
      pf_q  <= 1'b0;
    end else if (wr) begin
      fld_q <= wdata[10:0];
      pf_q  <= wdata[ws_pkg::PF_BIT];
    end
  end

  assign fields = fld_q;
  assign pf_en  = pf_q;
endmodule

// File: rtl/ws_region_table.sv
module ws_region_table
  import ws_pkg::*;
#(
  parameter int RGN_W = 8
) (
  input  logic [10:0]      fields,
  input  logic [RGN_W-1:0] rgn,
  output ws_pair_t         pair
);
  ws_pair_t tbl [NUM_RGN];

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    if (r >= WIN_BASE && r < WIN_BASE + 2*NUM_WIN) begin : g_win
      localparam int W = (r - WIN_BASE) / 2;
      assign tbl[r].ns = ns_map(fields[NS_LSB + FIELD_STEP*W +: 2]);
      assign tbl[r].sq = sq_map(W, fields[SQ_BIT + FIELD_STEP*W]);
    end else if (r == SAVE_RGN) begin : g_save
      assign tbl[r].ns = ns_map(fields[1:0]);
      assign tbl[r].sq = ns_map(fields[1:0]);
    end else begin : g_fixed
      assign tbl[r] = fixed_pair(r);
    end
  end

  logic in_range;
  assign in_range = (rgn < RGN_W'(NUM_RGN));

  always_comb begin
    pair = '0;
    if (in_range) pair = tbl[rgn[$clog2(NUM_RGN)-1:0]];
  end
endmodule

// File: rtl/ws_cost.sv
module ws_cost
  import ws_pkg::*;
(
  input  ws_pair_t            pair,
  input  logic                hit,
  input  logic                wide,
  input  logic                seq,
  output logic [WS_CNT_W-1:0] cost
);
  always_comb begin
    if (!hit)
      cost = '0;
    else if (!wide)
      cost = seq ? pair.sq : pair.ns;
    else if (seq)
      cost = (pair.sq << 1) + WS_CNT_W'(1);
    else
      cost = pair.ns + pair.sq + WS_CNT_W'(1);
  end
endmodule

// File: rtl/ws_stall_ctr.sv
module ws_stall_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cost,
  output logic             stall,
  output logic             done
);
  logic             busy_q;
  logic             fin_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      left_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (busy_q) begin
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          left_q <= left_q - CNT_W'(1);
        end
      end else if (start && cost != '0) begin
        busy_q <= 1'b1;
        left_q <= cost;
      end
    end
  end

  assign stall = busy_q;
  assign done  = fin_q | (start & ~busy_q & (cost == '0));
endmodule

// File: rtl/mem_wait_gen.sv
module mem_wait_gen
  import ws_pkg::*;
#(
  parameter int RGN_W = 8,
  parameter int CTL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             acc_start,
  input  logic [RGN_W-1:0] acc_rgn,
  input  logic             acc_wide,
  input  logic             acc_seq,
  output logic             stall_o,
  output logic             done_o,
  output logic             pf_en_o
);
  logic [10:0]         fields;
  ws_pair_t            pair;
  logic                hit;
  logic [WS_CNT_W-1:0] cost;

  ws_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .fields(fields), .pf_en(pf_en_o)
  );

  ws_region_table #(.RGN_W(RGN_W)) u_tbl (
    .fields(fields), .rgn(acc_rgn), .pair(pair)
  );

  assign hit = (acc_rgn < RGN_W'(NUM_RGN));

  ws_cost u_cost (
    .pair(pair), .hit(hit), .wide(acc_wide), .seq(acc_seq), .cost(cost)
  );

  ws_stall_ctr #(.CNT_W(WS_CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .start(acc_start), .cost(cost),
    .stall(stall_o), .done(done_o)
  );
endmodule

// File: rtl/ws_chk.sv
module ws_chk #(
  parameter int RGN_W = 8,
  parameter int CTL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             acc_start,
  input logic [RGN_W-1:0] acc_rgn,
  input logic             stall_o,
  input logic             done_o,
  input logic             pf_en_o
);
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(stall_o && done_o));

  p_end_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> done_o);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !acc_start) |=> (!done_o || acc_start));

  p_zero_rgn_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_start && !stall_o && acc_rgn > RGN_W'(15)) |-> done_o);

  p_nonzero_stalls_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_start && !stall_o && !done_o) |=> stall_o);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (stall_o || done_o));

  p_pf_r13: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (pf_en_o == $past(ctl_wdata[14])));
endmodule

bind mem_wait_gen ws_chk #(.RGN_W(RGN_W), .CTL_W(CTL_W)) u_ws_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .acc_start(acc_start), .acc_rgn(acc_rgn), .stall_o(stall_o),
  .done_o(done_o), .pf_en_o(pf_en_o)
);

// File: tb/test_mem_wait_gen.sv
`timescale 1ns/1ps
module test_mem_wait_gen;
  localparam int RGN_W = 8;
  localparam real HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        acc_start = 1'b0;
  logic [RGN_W-1:0] acc_rgn = '0;
  logic        acc_wide = 1'b0;
  logic        acc_seq = 1'b0;
  logic        stall_o, done_o, pf_en_o;

  int checks = 0;
  int fails  = 0;
  int spur   = 0;
  bit meas   = 0;
  int cnt    = 0;
  logic [15:0] cfg_sh = '0;

  typedef struct { int exp; string tag; } item_t;
  item_t q[$];
  item_t cur;

  always #(HALF) clk = ~clk;

  mem_wait_gen #(.RGN_W(RGN_W)) i_mem_wait_gen (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .acc_start(acc_start), .acc_rgn(acc_rgn), .acc_wide(acc_wide),
    .acc_seq(acc_seq), .stall_o(stall_o), .done_o(done_o), .pf_en_o(pf_en_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nmap(input logic [1:0] c);
    case (c) 2'd0: return 4; 2'd1: return 3; 2'd2: return 2; default: return 8; endcase
  endfunction

  function automatic int model(input logic [15:0] c, input int r, input bit w, input bit s);
    int n, sq;
    if (r > 15) return 0;
    case (r)
      2:       begin n = 2; sq = 2; end
      8, 9:    begin n = nmap(c[3:2]); sq = c[4]  ? 1 : 2; end
      10, 11:  begin n = nmap(c[6:5]); sq = c[7]  ? 1 : 4; end
      12, 13:  begin n = nmap(c[9:8]); sq = c[10] ? 1 : 8; end
      14:      begin n = nmap(c[1:0]); sq = n; end
      default: begin n = 0; sq = 0; end
    endcase
    if (!w) return s ? sq : n;
    return s ? 2*sq + 1 : n + sq + 1;
  endfunction

  // Monitor: pops one expected item per accepted start and times the access.
  always @(negedge clk) begin
    if (!rst) begin
      if (!meas) begin
        if (acc_start) begin
          if (q.size() == 0) begin
            chk(0, "R12 unexpected start", 1, 0);
          end else begin
            cur = q.pop_front();
            if (cur.exp == 0) begin
              chk(done_o && !stall_o, {cur.tag, " zero-cost done"}, int'(done_o), 1);
            end else begin
              if (done_o) chk(0, {cur.tag, " early done"}, 1, 0);
              meas = 1; cnt = 0;
            end
          end
        end else if (done_o) begin
          spur++;
        end
      end else begin
        if (done_o) begin
          chk(cnt == cur.exp && !stall_o, {cur.tag, " stall cycles"}, cnt, cur.exp);
          meas = 0;
        end else if (stall_o) begin
          cnt++;
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic wait_idle();
    while (meas) @(negedge clk);
  endtask

  task automatic acc(input int r, input bit w, input bit s, input string tag);
    item_t it;
    it.exp = model(cfg_sh, r, w, s);
    it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    acc_rgn = RGN_W'(r); acc_wide = w; acc_seq = s; acc_start = 1'b1;
    @(posedge clk); #1;
    acc_start = 1'b0;
    wait_idle();
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_wdata = v;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
    cfg_sh = v;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(!stall_o, "R8 stall after reset", int'(stall_o), 0);
    chk(!done_o,  "R8 done after reset",  int'(done_o), 0);
    chk(!pf_en_o, "R8 prefetch after reset", int'(pf_en_o), 0);

    // R1, R10, R3: fixed regions with default word
    acc(0, 0, 0, "R1 R10 region0 16ns");
    acc(2, 0, 0, "R1 region2 16ns");
    acc(2, 0, 1, "R1 region2 16seq");
    acc(2, 1, 0, "R3 region2 32ns");
    acc(2, 1, 1, "R3 region2 32seq");
    acc(3, 1, 0, "R3 region3 32ns");
    acc(15, 1, 1, "R1 region15 32seq");
    // R8: cartridge and save defaults
    acc(8, 0, 0, "R8 win0 default ns");
    acc(11, 0, 1, "R8 win1 default seq");
    acc(12, 1, 1, "R8 R3 win2 default 32seq");
    acc(14, 1, 0, "R8 save default 32ns");
    // R2: out-of-range regions
    acc(16, 1, 0, "R2 region16 32ns");
    acc(200, 0, 1, "R2 region200 16seq");
    acc(255, 1, 1, "R2 region255 32seq");

    // R4, R5, R7: sweep each window's codes and sequential bit
    for (int w = 0; w < 3; w++) begin
      for (int c = 0; c < 4; c++) begin
        logic [15:0] v;
        v = '0;
        v[2 + 3*w +: 2] = 2'(c);
        v[4 + 3*w] = c[0];
        wr_cfg(v);
        acc(8 + 2*w, 0, 0, "R4 base ns");
        acc(9 + 2*w, 0, 0, "R7 mirror ns");
        acc(8 + 2*w, 0, 1, "R5 base seq");
        acc(9 + 2*w, 1, 1, "R5 R7 mirror 32seq");
        acc(8 + 2*w, 1, 0, "R3 base 32ns");
      end
    end

    // R6: save-RAM codes
    for (int c = 0; c < 4; c++) begin
      wr_cfg(16'(c));
      acc(14, 0, 0, "R6 save ns");
      acc(14, 0, 1, "R6 save seq");
      acc(14, 1, 1, "R6 save 32seq");
    end

    // R11 + R12: write and stray start during a stall
    wr_cfg(16'h0000);
    begin
      item_t it;
      it.exp = model(cfg_sh, 12, 1, 0);
      it.tag = "R11 R12 latched count";
      q.push_back(it);
      @(posedge clk); #1;
      acc_rgn = 8'd12; acc_wide = 1; acc_seq = 0; acc_start = 1;
      @(posedge clk); #1; acc_start = 0;
      @(posedge clk); #1; ctl_wr = 1; ctl_wdata = 16'h0300;
      @(posedge clk); #1; ctl_wr = 0;
      @(posedge clk); #1; acc_rgn = 8'd0; acc_start = 1;
      @(posedge clk); #1; acc_start = 0;
      wait_idle();
      cfg_sh = 16'h0300;
    end
    acc(12, 1, 0, "R11 new settings next access");

    // R11: write in the same cycle as start uses old settings
    begin
      item_t it;
      it.exp = model(cfg_sh, 8, 0, 0);
      it.tag = "R11 same-cycle write";
      q.push_back(it);
      @(posedge clk); #1;
      ctl_wr = 1; ctl_wdata = 16'h000C;
      acc_rgn = 8'd8; acc_wide = 0; acc_seq = 0; acc_start = 1;
      @(posedge clk); #1; ctl_wr = 0; acc_start = 0;
      wait_idle();
      cfg_sh = 16'h000C;
    end
    acc(8, 0, 0, "R11 after same-cycle write");

    // R13: prefetch bit and reserved bits
    wr_cfg(16'h4000);
    @(negedge clk);
    chk(pf_en_o, "R13 prefetch set", int'(pf_en_o), 1);
    wr_cfg(16'hB800);
    @(negedge clk);
    chk(!pf_en_o, "R13 prefetch clear", int'(pf_en_o), 0);
    acc(8, 0, 0, "R13 reserved bits win0");
    acc(14, 1, 0, "R13 reserved bits save");

    repeat (4) @(negedge clk);
    chk(spur == 0, "R12 no extra done pulses", spur, 0);
    chk(q.size() == 0, "R9 all accesses completed", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule